// File: doc/BRIEF.md
# Oversampled Serial Slave with SCLK Inactivity Resync

This block is the serial front end of a converter-style device. A master clock much faster than the serial clock oversamples SCLK, the active-low select and the data input through two-flop synchronisers. Edges of the synchronised SCLK then drive all of the framing. Command bytes arrive MSB first on SCLK rising edges, and each complete byte is handed to the core with a one-cycle strobe. Result bytes leave MSB first, and the output bit advances after each SCLK falling edge. A result word of `NBYTES` bytes is latched when the core pulses `res_valid`. An active-low ready line then tells the host that unread data waits.

The host may hold the select low permanently, so framing cannot depend on select edges alone. While selected, a counter in the master clock domain measures how long SCLK has held one level. When that time reaches the limit, the bit count and the byte position return to a byte boundary. Two limits are available: a long one (`TMO_LONG`, default 4096) and a short one (`TMO_SHORT`, default 256), chosen by `tmo_short`.

The link state machine has three states. `LNK_IDLE` means not selected. `LNK_FRAME` means selected and at a byte boundary. `LNK_BITS` means selected and partway through a byte. The transitions are:
- select → IDLE to FRAME
- first rising edge → FRAME to BITS
- eighth rising edge or timeout → BITS to FRAME
- deselect → FRAME or BITS to IDLE

The ready state machine also has three states. `RDY_EMPTY` means nothing is unread. `RDY_FRESH` means unread data is waiting and the ready line is low. `RDY_BLIP` holds the ready line high for one cycle when new data replaces an unread result. Its transitions are:
- result → EMPTY to FRESH
- result → FRESH to BLIP
- first-byte read → FRESH to EMPTY
- BLIP to FRESH after one cycle

Top module: `spi_conv_slave`

## Requirements
- R1: After reset, `drdy_n` is 1, `dout_oe` is 0 and `cmd_valid` is 0.
- R2: DIN is sampled on SCLK rising edges, MSB first. After the eighth rising edge of a byte, `cmd_byte` holds that byte and `cmd_valid` is 1 for exactly one master cycle.
- R3: The result word is split into bytes in this order: byte 0 = `res_data[23:16]`, byte 1 = `[15:8]`, byte 2 = `[7:0]`. Bytes go out MSB first. After selection, DOUT shows bit 7 of byte 0 before the first rising edge. DOUT advances one bit after each falling edge. After the last byte it wraps to byte 0.
- R4: `dout_oe` goes high within 5 master cycles of select going low. It goes low, with `dout` at 0, within 5 master cycles of select going high.
- R5: With select held low, consecutive bytes frame back to back, and each read returns the next result byte.
- R6: With `tmo_short`=0, if SCLK holds one level for `TMO_LONG` master cycles while selected, the partial byte is dropped. The next rising edge is bit 7 of a new byte, and DOUT restarts at byte 0.
- R7: With `tmo_short`=1, the limit is `TMO_SHORT` cycles. With `tmo_short`=0, a 1000-cycle pause in the middle of a byte does not break the byte.
- R8: Deselecting clears the bit count and byte position, so the next byte is framed fresh and reads byte 0.
- R9: `drdy_n` falls no earlier than one master cycle after the result buffer takes new data. After a `res_valid` pulse into an empty state, `drdy_n` is still 1 one cycle later and 0 two cycles later.
- R10: Completing the first byte read after `drdy_n` falls returns `drdy_n` to 1 until the next result.
- R11: A new result that arrives while the previous one is unread drives `drdy_n` high for one cycle, then low again.
- R12: If a new result reaches the ready logic in the same cycle as the first-byte read completes, the new result wins. `drdy_n` pulses high for one cycle and then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from host |
| tmo_short | input | 1 | 1 selects the short inactivity limit |
| res_valid | input | 1 | Core pulses to latch a new result |
| res_data | input | NBYTES*8 | Result word |
| dout | output | 1 | Serial data to host (0 when disabled) |
| dout_oe | output | 1 | Output enable for the DOUT pad driver |
| drdy_n | output | 1 | Active-low data ready |
| cmd_byte | output | 8 | Last received command byte |
| cmd_valid | output | 1 | One-cycle strobe per received byte |

## Verification
Two events can land in the same master cycle: a read completing and a new result reaching the ready logic. The bench provokes this by raising `res_valid` in the cycle in which the synchronised eighth rising edge of a first byte is detected. It then checks that `drdy_n` reads 1 in the next cycle and 0 in the one after, not staying high. The timeout and an SCLK edge can also compete. Pauses just under and well over each limit show which one took effect, and the received command byte and the byte read back reveal the outcome.

// File: rtl/spi_sl_pkg.sv
package spi_sl_pkg;
    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_FRAME,
        LNK_BITS
    } link_st_t;

    typedef enum logic [1:0] {
        RDY_EMPTY,
        RDY_FRESH,
        RDY_BLIP
    } rdy_st_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= g_stage[g-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_tmo.sv
module spi_tmo #(
    parameter int LONG  = 4096,
    parameter int SHORT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic edge_seen,
    input  logic short_sel,
    output logic hit
);
    localparam int CW = $clog2(LONG + 1);

    logic [CW-1:0] quiet_cnt;
    logic [CW-1:0] lim;

    assign lim = short_sel ? CW'(SHORT) : CW'(LONG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   quiet_cnt <= '0;
        else if (!arm || edge_seen)   quiet_cnt <= '0;
        else if (quiet_cnt < lim)     quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign hit = arm && !edge_seen && (quiet_cnt == lim - 1'b1);

    // one resync per quiet stretch
    p_tmo_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // an SCLK edge always restarts the quiet measurement
    p_edge_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && edge_seen) |=> (quiet_cnt == '0));
endmodule

// File: rtl/spi_ready.sv
module spi_ready
    import spi_sl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_now,
    input  logic new_res,
    input  logic read_done,
    output logic drdy_n
);
    rdy_st_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RDY_EMPTY;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RDY_EMPTY: if (new_res && !wr_now) nxt = RDY_FRESH;
            RDY_FRESH: begin
                if (new_res)        nxt = RDY_BLIP;
                else if (read_done) nxt = RDY_EMPTY;
            end
            RDY_BLIP:  if (!wr_now) nxt = RDY_FRESH;
            default:   nxt = RDY_EMPTY;
        endcase
    end

    always_comb drdy_n = (st != RDY_FRESH);

    // buffer write never coincides with ready falling
    p_data_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && drdy_n) |=> drdy_n);

    // unread data replaced: ready re-pulses high
    p_repulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && new_res) |=> drdy_n);

    // collision: new result beats the read
    p_new_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && new_res && read_done) |=> (drdy_n && (st == RDY_BLIP)));

    // read of first byte releases ready
    p_read_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && read_done && !new_res) |=> drdy_n);
endmodule

// File: rtl/spi_conv_slave.sv
module spi_conv_slave
    import spi_sl_pkg::*;
#(
    parameter int NBYTES      = 3,
    parameter int TMO_LONG    = 4096,
    parameter int TMO_SHORT   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  din,
    input  logic                  tmo_short,
    input  logic                  res_valid,
    input  logic [NBYTES*8-1:0]   res_data,
    output logic                  dout,
    output logic                  dout_oe,
    output logic                  drdy_n,
    output logic [7:0]            cmd_byte,
    output logic                  cmd_valid
);
    localparam int NBITS = NBYTES * 8;
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int PW    = $clog2(NBITS);

    logic sclk_s, cs_s, din_s, sclk_d;
    logic sel, in_frame, sclk_rise, sclk_fall, tmo_hit, byte_end, read_done;
    logic [2:0]        bit_cnt, tx_pos;
    logic [IDX_W-1:0]  byte_idx, tx_bidx;
    logic [7:0]        rx_sh;
    logic [NBITS-1:0]  rbuf;
    logic              res_d;
    logic [PW-1:0]     bpos;
    link_st_t          lnk_st, lnk_nxt;

    spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, din}),
        .q     ({sclk_s, cs_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sel       = !cs_s;
    assign in_frame  = sel && (lnk_st != LNK_IDLE);
    assign sclk_rise = in_frame &&  sclk_s && !sclk_d;
    assign sclk_fall = in_frame && !sclk_s &&  sclk_d;
    assign byte_end  = sclk_rise && (bit_cnt == 3'd7);
    assign read_done = byte_end && (byte_idx == '0);

    spi_tmo #(
        .LONG  (TMO_LONG),
        .SHORT (TMO_SHORT)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (sel),
        .edge_seen (sclk_s ^ sclk_d),
        .short_sel (tmo_short),
        .hit       (tmo_hit)
    );

    spi_ready u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_now    (res_valid),
        .new_res   (res_d),
        .read_done (read_done),
        .drdy_n    (drdy_n)
    );

    // link state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lnk_st <= LNK_IDLE;
        else        lnk_st <= lnk_nxt;
    end

    always_comb begin
        lnk_nxt = lnk_st;
        unique case (lnk_st)
            LNK_IDLE:  if (sel) lnk_nxt = LNK_FRAME;
            LNK_FRAME: begin
                if (!sel)           lnk_nxt = LNK_IDLE;
                else if (sclk_rise) lnk_nxt = LNK_BITS;
            end
            LNK_BITS: begin
                if (!sel)                     lnk_nxt = LNK_IDLE;
                else if (tmo_hit || byte_end) lnk_nxt = LNK_FRAME;
            end
            default: lnk_nxt = LNK_IDLE;
        endcase
    end

    // shift, framing and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            byte_idx  <= '0;
            tx_pos    <= '0;
            tx_bidx   <= '0;
            rx_sh     <= '0;
            cmd_byte  <= '0;
            cmd_valid <= 1'b0;
            dout_oe   <= 1'b0;
            rbuf      <= '0;
            res_d     <= 1'b0;
        end else begin
            cmd_valid <= byte_end;
            dout_oe   <= sel;
            res_d     <= res_valid;
            if (res_valid) rbuf <= res_data;
            if (!in_frame || tmo_hit) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
                tx_pos   <= '0;
                tx_bidx  <= '0;
            end else begin
                if (sclk_rise) begin
                    rx_sh   <= {rx_sh[6:0], din_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 3'd7) begin
                        cmd_byte <= {rx_sh[6:0], din_s};
                        byte_idx <= (byte_idx == IDX_W'(NBYTES - 1)) ? '0
                                                                     : byte_idx + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    tx_pos  <= bit_cnt;
                    tx_bidx <= byte_idx;
                end
            end
        end
    end

    always_comb bpos = PW'(NBITS - 1) - PW'({tx_bidx, 3'b000}) - PW'(tx_pos);
    assign dout = dout_oe & rbuf[bpos];

    // select released: driver disabled one cycle later
    p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !dout_oe);

    // byte strobe is a single cycle
    p_byte_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // timeout lands on a byte boundary
    p_tmo_resync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (bit_cnt == 3'd0 && byte_idx == '0 && lnk_st != LNK_BITS));

    // boundary state agrees with the bit counter
    p_frame_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_st == LNK_FRAME) |-> (bit_cnt == 3'd0));

    // output bit moves only after a falling edge, a new result or a resync
    p_dout_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(sel) && $past(in_frame) && !$past(sclk_fall)
         && !$past(res_valid) && !$past(tmo_hit)) |-> $stable(dout));
endmodule

// File: tb/test_spi_conv_slave.sv
module test_spi_conv_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int TMO_L      = 4096;

    logic        clk = 1'b0;
    logic        rst_n, sclk, cs_n, din, tmo_short, res_valid;
    logic [23:0] res_data;
    logic        dout, dout_oe, drdy_n, cmd_valid;
    logic [7:0]  cmd_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] exp_cmd [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_conv_slave #(.NBYTES(3), .TMO_LONG(TMO_L), .TMO_SHORT(256)) i_spi_conv_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .tmo_short(tmo_short), .res_valid(res_valid), .res_data(res_data),
        .dout(dout), .dout_oe(dout_oe), .drdy_n(drdy_n),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // scoreboard monitor: pops expected command bytes (R2)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cmd_valid === 1'b1) begin
            if (exp_cmd.size() == 0) chk("R2 unexpected byte", {24'h0, cmd_byte}, 32'hFFFF);
            else                     chk("R2 cmd byte", {24'h0, cmd_byte}, {24'h0, exp_cmd.pop_front()});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic spi_bit(input logic b, output logic o);
        @(negedge clk) din = b;
        repeat (H) @(negedge clk);
        o = dout;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] m, output logic [7:0] s);
        logic bt;
        exp_cmd.push_back(m);
        for (int i = 7; i >= 0; i--) begin
            spi_bit(m[i], bt);
            s[i] = bt;
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic load(input logic [23:0] d);
        @(negedge clk) begin res_data = d; res_valid = 1'b1; end
        @(negedge clk) res_valid = 1'b0;
    endtask

    task automatic reframe();
        @(negedge clk) cs_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] s;
        logic       bt;
        logic [7:0] m;
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
        tmo_short = 1'b0; res_valid = 1'b0; res_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drdy_n", {31'h0, drdy_n}, 32'h1);
        chk("R1 dout_oe", {31'h0, dout_oe}, 32'h0);
        chk("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);

        // R9: ready lags buffer write
        load(24'h813CE7);
        chk("R9 drdy_n one cycle after", {31'h0, drdy_n}, 32'h1);
        @(negedge clk);
        chk("R9 drdy_n two cycles after", {31'h0, drdy_n}, 32'h0);

        // R4, R3, R10, R5
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 oe after select", {31'h0, dout_oe}, 32'h1);
        chk("R3 first bit", {31'h0, dout}, 32'h1);
        spi_byte(8'h5A, s);
        chk("R3 byte0", {24'h0, s}, 32'h81);
        chk("R10 drdy_n released", {31'h0, drdy_n}, 32'h1);
        spi_byte(8'h0F, s);
        chk("R5 byte1", {24'h0, s}, 32'h3C);
        spi_byte(8'hF0, s);
        chk("R3 byte2", {24'h0, s}, 32'hE7);
        spi_byte(8'h99, s);
        chk("R3 wrap", {24'h0, s}, 32'h81);

        // R8: deselect mid byte
        for (int i = 0; i < 4; i++) spi_bit(1'b1, bt);
        @(negedge clk) cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 oe after release", {31'h0, dout_oe}, 32'h0);
        chk("R4 dout low", {31'h0, dout}, 32'h0);
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        spi_byte(8'h3C, s);
        chk("R8 reads byte0", {24'h0, s}, 32'h81);

        // R11: re-pulse on unread replacement
        load(24'h112233);
        repeat (4) @(negedge clk);
        @(negedge clk) begin res_data = 24'h445566; res_valid = 1'b1; end
        @(negedge clk) res_valid = 1'b0;
        chk("R11 still low", {31'h0, drdy_n}, 32'h0);
        @(negedge clk);
        chk("R11 high pulse", {31'h0, drdy_n}, 32'h1);
        @(negedge clk);
        chk("R11 low again", {31'h0, drdy_n}, 32'h0);

        // R12: result and read completion in the same cycle
        reframe();
        m = 8'h6E;
        exp_cmd.push_back(m);
        for (int i = 7; i >= 1; i--) begin
            spi_bit(m[i], bt);
            s[i] = bt;
        end
        @(negedge clk) din = m[0];
        repeat (H) @(negedge clk);
        s[0] = dout;
        sclk = 1'b1;
        @(negedge clk) begin res_data = 24'h778899; res_valid = 1'b1; end
        @(negedge clk) res_valid = 1'b0;
        @(negedge clk);
        chk("R12 pulse high", {31'h0, drdy_n}, 32'h1);
        @(negedge clk);
        chk("R12 new result wins", {31'h0, drdy_n}, 32'h0);
        repeat (H - 4) @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        chk("R12 read data", {24'h0, s}, 32'h44);

        // R6: long timeout drops partial byte
        spi_bit(1'b1, bt); spi_bit(1'b0, bt); spi_bit(1'b1, bt);
        repeat (TMO_L + 50) @(negedge clk);
        spi_byte(8'hA5, s);
        chk("R6 restart at byte0", {24'h0, s}, 32'h77);

        // R7: pause below long limit keeps the byte
        m = 8'hC3;
        exp_cmd.push_back(m);
        for (int i = 7; i >= 5; i--) spi_bit(m[i], bt);
        repeat (1000) @(negedge clk);
        for (int i = 4; i >= 0; i--) spi_bit(m[i], bt);
        repeat (H) @(negedge clk);

        // R7: short limit
        tmo_short = 1'b1;
        spi_bit(1'b0, bt); spi_bit(1'b1, bt); spi_bit(1'b1, bt);
        repeat (300) @(negedge clk);
        spi_byte(8'h5A, s);
        chk("R7 short resync byte0", {24'h0, s}, 32'h77);
        tmo_short = 1'b0;

        repeat (20) @(negedge clk);
        chk("R2 scoreboard drained", exp_cmd.size(), 32'h0);
        finish_run();
    end
endmodule